// File: doc/BRIEF.md
# I2C Register-Access Slave

This block sits on a two-wire I2C bus as a slave and opens an 8-bit register file with 128 locations to the bus master. It samples SCL and SDA with the system clock and finds START, repeated START and STOP from the sampled edges. It acknowledges its own device address and pulls SDA low through an open-drain enable. The upper six bits of that address are fixed and the lowest bit comes from a strap pin, so two copies can share one bus.

After the address, the master sends a pointer byte. The low seven bits name a register. The top bit decides whether the pointer steps forward after each data byte. The master then writes data bytes, or it issues a repeated START with the read bit set and clocks data out. The register file sits behind a plain synchronous port: a one-cycle write strobe, and a one-cycle read strobe whose data returns on the following clock.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset, sda_oe, reg_we and reg_re are all low and the slave waits for a START.
- R2: A first byte whose upper seven bits equal 1011100 with the last bit replaced by strap_a0 (0x5C or 0x5D) is acknowledged by SDA held low while SCL is high on the ninth clock. The byte's bit 0 selects read (1) or write (0).
- R3: A first byte with any other address gets no acknowledge. Until the next START, no register access happens and SDA stays released.
- R4: The byte after a write-address is acknowledged and loads the pointer. Bits 6:0 are the register number and bit 7 = 1 enables stepping.
- R5: Every received data byte is acknowledged and written once to the pointed register, through a single-cycle reg_we with reg_addr and reg_wdata. Bits arrive MSB first.
- R6: With stepping enabled, the pointer advances by one after each data byte, written or read, and wraps from 127 to 0.
- R7: With stepping disabled, every data byte of a burst uses the same register, for writes and for reads.
- R8: Read data is sent MSB first, starting at the pointer kept from the earlier write phase. Another byte follows each master ACK. After a master NACK the slave releases SDA and sends nothing more.
- R9: A STOP at any point releases SDA and returns the slave to idle. A byte cut short by a STOP writes nothing.
- R10: reg_re and reg_we are single-cycle pulses and never high together. reg_rdata is taken on the clock after reg_re, and exactly one read is issued per byte sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain), 0 releases it |
| strap_a0 | input | 1 | Strap for the lowest device-address bit |
| reg_addr | output | 7 | Register number for the current access |
| reg_wdata | output | 8 | Data to be written |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after reg_re |

## Verification
On one SCL falling edge, the slave both commits a received data byte to the register port and starts driving its acknowledge. On one SCL rising edge it both samples the master's ACK and fetches the next read byte while stepping the pointer. Multi-byte bursts with stepping on and off, including one that crosses register 127, make these pairs coincide on every byte. Each burst is judged by the ACK bits seen on the line, by readback through a separate transaction, and by counting reg_we and reg_re pulses against the bytes moved.

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [5:0] ADDR_HI = 6'b101110,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       strap_a0,
  output logic [6:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  output logic       reg_re,
  input  logic [7:0] reg_rdata
);
  localparam int PW = 7;
  localparam int BW = 8;

  typedef enum logic [2:0] {IDLE, RX, RX_ACK, TX, TX_ACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_SUB, K_DATA} kind_t;

  st_t            st;
  kind_t          kind;
  logic [SYNC-1:0] scl_s, sda_s;
  logic           scl_d, sda_d;
  logic [BW-1:0]  sh;
  logic [3:0]     cnt;
  logic [PW-1:0]  ptr;
  logic           inc, rw, mack, rd_pend;

  wire scl_q    = scl_s[SYNC-1];
  wire sda_q    = sda_s[SYNC-1];
  wire start    = scl_q & scl_d & sda_d & ~sda_q;
  wire stop     = scl_q & scl_d & ~sda_d & sda_q;
  wire scl_rise = scl_q & ~scl_d;
  wire scl_fall = ~scl_q & scl_d;
  wire [PW-1:0] ptr_nx = ptr + {{(PW-1){1'b0}}, inc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[SYNC-2:0], scl_i};
      sda_s <= {sda_s[SYNC-2:0], sda_i};
      scl_d <= scl_q;
      sda_d <= sda_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; kind <= K_ADDR; sh <= '0; cnt <= '0; ptr <= '0;
      inc <= 1'b0; rw <= 1'b0; mack <= 1'b0; rd_pend <= 1'b0;
      sda_oe <= 1'b0; reg_addr <= '0; reg_wdata <= '0;
      reg_we <= 1'b0; reg_re <= 1'b0;
    end else begin
      reg_we  <= 1'b0;
      reg_re  <= 1'b0;
      rd_pend <= reg_re;
      if (rd_pend) sh <= reg_rdata;
      if (start) begin
        st <= RX; kind <= K_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop) begin
        st <= IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          RX: begin
            if (scl_rise) begin
              sh  <= {sh[BW-2:0], sda_q};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              case (kind)
                K_ADDR: begin
                  if (sh[7:1] == {ADDR_HI, strap_a0}) begin
                    rw <= sh[0]; sda_oe <= 1'b1; st <= RX_ACK;
                    if (sh[0]) begin
                      reg_re <= 1'b1; reg_addr <= ptr; ptr <= ptr_nx;
                    end
                  end else begin
                    st <= IDLE;
                  end
                end
                K_SUB: begin
                  ptr <= sh[PW-1:0]; inc <= sh[7]; sda_oe <= 1'b1; st <= RX_ACK;
                end
                default: begin
                  reg_we <= 1'b1; reg_addr <= ptr; reg_wdata <= sh; ptr <= ptr_nx;
                  sda_oe <= 1'b1; st <= RX_ACK;
                end
              endcase
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (kind == K_ADDR && rw) begin
                st <= TX; sda_oe <= ~sh[7];
              end else begin
                sda_oe <= 1'b0; st <= RX;
                kind <= (kind == K_ADDR) ? K_SUB : K_DATA;
              end
            end
          end
          TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0; st <= TX_ACK;
              end else begin
                sh <= {sh[BW-2:0], 1'b0}; sda_oe <= ~sh[6]; cnt <= cnt + 4'd1;
              end
            end
          end
          TX_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_q;
              if (!sda_q) begin
                reg_re <= 1'b1; reg_addr <= ptr; ptr <= ptr_nx;
              end
            end else if (scl_fall) begin
              if (mack) begin
                st <= TX; cnt <= '0; sda_oe <= ~sh[7];
              end else begin
                st <= IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r1_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE) |-> !sda_oe);
  a_r3_no_drive_on_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX && kind == K_ADDR) |-> !sda_oe);
  a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (st == IDLE && !sda_oe));
  a_r5_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  a_r10_re_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || reg_re) |-> (ptr == reg_addr + (inc ? 7'd1 : 7'd0)));
endmodule

// File: tb/tb_i2c_reg_slave.sv
module tb_i2c_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_oe, reg_we, reg_re;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  wire sda_bus = sda_m & ~sda_oe;

  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  int tests = 0, fails = 0, we_cnt = 0, re_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_a0(strap), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (reg_we) begin mem[reg_addr] <= reg_wdata; we_cnt <= we_cnt + 1; end
    if (reg_re) begin reg_rdata <= mem[reg_addr]; re_cnt <= re_cnt + 1; end
  end

  // 15-bit entries: {register, data}
  localparam logic [14:0] VEC [8] = '{
    {7'h08, 8'h3C}, {7'h09, 8'hA5}, {7'h0A, 8'h00}, {7'h0F, 8'hFF},
    {7'h40, 8'h81}, {7'h55, 8'h7E}, {7'h00, 8'h12}, {7'h7F, 8'hC3}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(H); scl = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl = 1'b0; tick(2);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(H); scl = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(H); scl = 1'b1; tick(H/2); ack = ~sda_bus; tick(H/2);
    scl = 1'b0; tick(2);
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl = 1'b1; tick(H/2); b[i] = sda_bus; tick(H/2); scl = 1'b0; tick(2);
    end
    sda_m = ~ack; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(2); sda_m = 1'b1;
  endtask

  task automatic i2c_write(input string tag, input logic [6:0] dev, input logic [7:0] sub, input int n);
    logic a;
    logic [6:0] p;
    bus_start;
    send_byte({dev, 1'b0}, a); check({tag, " addr ack"}, a, 1);
    send_byte(sub, a);         check({tag, " sub ack"}, a, 1);
    p = sub[6:0];
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a); check({tag, " data ack"}, a, 1);
      exp_mem[p] = wbuf[k];
      if (sub[7]) p = p + 7'd1;
    end
    bus_stop;
  endtask

  task automatic i2c_read(input string tag, input logic [6:0] dev, input logic [7:0] sub, input int n);
    logic a;
    bus_start;
    send_byte({dev, 1'b0}, a); check({tag, " addr ack"}, a, 1);
    send_byte(sub, a);         check({tag, " sub ack"}, a, 1);
    bus_start;
    send_byte({dev, 1'b1}, a); check({tag, " read addr ack"}, a, 1);
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
    check({tag, " released after NACK"}, sda_oe, 0);
    bus_stop;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report;
  end

  initial begin
    logic a;
    int w0, r0;
    tick(4);
    check("R1 sda_oe reset", sda_oe, 0);
    check("R1 reg_we reset", reg_we, 0);
    check("R1 reg_re reset", reg_re, 0);
    rst_n = 1'b1;
    tick(4);
    check("R1 sda_oe idle", sda_oe, 0);

    // R2 R4 R5 R8: table of single writes, each read back
    for (int v = 0; v < 8; v++) begin
      wbuf[0] = VEC[v][7:0];
      i2c_write("R5 vec write", 7'h5C, {1'b0, VEC[v][14:8]}, 1);
      i2c_read("R8 vec read", 7'h5C, {1'b0, VEC[v][14:8]}, 1);
      check("R5 vec readback", rbuf[0], VEC[v][7:0]);
    end

    // R3: wrong address ignored
    w0 = we_cnt; r0 = re_cnt;
    bus_start;
    send_byte({7'h5D, 1'b0}, a); check("R3 foreign addr nack", a, 0);
    send_byte(8'h30, a);         check("R3 no ack after foreign", a, 0);
    send_byte(8'hEE, a);
    bus_stop;
    check("R3 no write", we_cnt - w0, 0);
    check("R3 no read", re_cnt - r0, 0);
    i2c_read("R3 reg untouched", 7'h5C, 8'h30, 1);
    check("R3 reg 0x30 unchanged", rbuf[0], exp_mem[7'h30]);

    // R2: strap selects lowest address bit
    strap = 1'b1; tick(4);
    bus_start; send_byte({7'h5C, 1'b0}, a); bus_stop;
    check("R2 0x5C nack with strap=1", a, 0);
    wbuf[0] = 8'h66;
    i2c_write("R2 strap write", 7'h5D, 8'h31, 1);
    i2c_read("R2 strap read", 7'h5D, 8'h31, 1);
    check("R2 strap readback", rbuf[0], 8'h66);
    strap = 1'b0; tick(4);

    // R6: stepping write burst
    w0 = we_cnt;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    i2c_write("R6 inc burst", 7'h5C, 8'h90, 3);
    check("R5 one strobe per byte", we_cnt - w0, 3);
    for (int k = 0; k < 3; k++) begin
      i2c_read("R6 inc readback", 7'h5C, 8'h10 + 8'(k), 1);
      check("R6 inc burst value", rbuf[0], wbuf[k]);
    end

    // R7: fixed pointer write burst
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
    i2c_write("R7 fixed burst", 7'h5C, 8'h20, 3);
    i2c_read("R7 fixed readback", 7'h5C, 8'h20, 1);
    check("R7 last byte kept", rbuf[0], 8'hA3);
    i2c_read("R7 neighbour", 7'h5C, 8'h21, 1);
    check("R7 neighbour unchanged", rbuf[0], exp_mem[7'h21]);

    // R6: wrap 127 -> 0
    wbuf[0] = 8'hE7; wbuf[1] = 8'hE0;
    i2c_write("R6 wrap write", 7'h5C, 8'hFF, 2);
    i2c_read("R6 wrap read0", 7'h5C, 8'h00, 1);
    check("R6 wrap reg 0", rbuf[0], 8'hE0);
    i2c_read("R6 wrap read burst", 7'h5C, 8'hFF, 2);
    check("R6 wrap burst 127", rbuf[0], 8'hE7);
    check("R6 wrap burst 0", rbuf[1], 8'hE0);

    // R8 R10: stepping read burst
    r0 = re_cnt;
    i2c_read("R8 burst read", 7'h5C, 8'h90, 3);
    check("R10 one fetch per byte", re_cnt - r0, 3);
    for (int k = 0; k < 3; k++) check("R8 burst value", rbuf[k], exp_mem[7'h10 + 7'(k)]);

    // R7: fixed pointer read burst
    i2c_read("R7 fixed read", 7'h5C, 8'h20, 3);
    for (int k = 0; k < 3; k++) check("R7 fixed read value", rbuf[k], 8'hA3);

    // R9: STOP inside a data byte
    w0 = we_cnt;
    bus_start;
    send_byte({7'h5C, 1'b0}, a);
    send_byte(8'h32, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_stop;
    tick(4);
    check("R9 sda released", sda_oe, 0);
    check("R9 no partial write", we_cnt - w0, 0);
    i2c_read("R9 reg intact", 7'h5C, 8'h32, 1);
    check("R9 reg 0x32 unchanged", rbuf[0], exp_mem[7'h32]);

    report;
  end
endmodule